// File: doc/BRIEF.md
# Integer ALU Status-Flag Generator

This block sits beside a 32-bit integer ALU and turns each operation's operands, result and carry-out into the architectural status flags. It computes carry, parity, auxiliary (nibble) carry, zero, sign and overflow for 8-, 16- or 32-bit operand sizes. The flags are registered one clock after the operation is presented. They are packed into a 32-bit flags word together with a set of control flags that are held in a register and written by a separate enable.

The block also produces the signed pointer step that string operations add to their source and destination pointers. The step's magnitude is the operand size in bytes, and its sign comes from the stored direction flag. The ALU datapath is not part of this block: the carry-out or borrow, and for shifts the bit shifted out, arrive on an input.

Top module: `alu_status_flags`

## Requirements
- R1: Packed word layout. Carry is at bit 0, parity at bit 2, auxiliary carry at bit 4, zero at bit 6, sign at bit 7 and overflow at bit 11. Bit 1 always reads 1. Bits 3, 5, 15 and 22–31 always read 0. After reset the word is 0x00000002.
- R2: The status flags appear on `flags_word` at the first rising edge after the inputs are applied. Carry equals `carry_in` for add (code 0), subtract (code 1) and shift (code 3), and carry is 0 for logic (code 2).
- R3: Parity is 1 when the low 8 bits of the result hold an even number of ones.
- R4: For add and subtract, auxiliary carry is bit 4 of (a XOR b XOR result), which marks a carry or borrow across the bit 3 to bit 4 boundary. For logic and shift it is 0.
- R5: Zero is 1 when every result bit within the operand size is 0. Size codes are 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, and code 3 acts as 32 bits.
- R6: Sign equals the most significant result bit for the operand size.
- R7: Overflow rules. For add, overflow is set when both operand signs match and the result sign differs from them. For subtract (a − b), it is set when the operand signs differ and the result sign differs from a. For shift, it is set when the result sign differs from a. For logic, it is 0. All signs are taken at the operand size.
- R8: When `ctl_we` is 1 at a clock edge, the control bits are loaded from the same positions of `ctl_wdata`: bits 8, 9, 10, 12–13, 14 and 16–21. All other `ctl_wdata` bits are ignored. When `ctl_we` is 0, the control bits hold their value.
- R9: `ptr_step` is +1, +2 or +4 for size codes 0, 1 and 2 (or 3) when the stored direction bit 10 is 0. It is the negated value when bit 10 is 1.
- R10: An active-low reset clears all status and control flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_class | input | 2 | Operation class: 0 add, 1 subtract, 2 logic, 3 shift |
| op_size | input | 2 | Operand size: 0 byte, 1 half, 2 word, 3 word |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| result | input | DATA_W | ALU result |
| carry_in | input | 1 | Carry-out or borrow, or the bit shifted out on shifts |
| ctl_we | input | 1 | Control-flag write enable |
| ctl_wdata | input | 32 | Control-flag write data, in word positions |
| flags_word | output | 32 | Packed flags word |
| ptr_step | output | STEP_W | Signed string pointer step |

## Verification
Random add and subtract results, built from real sums and differences of random operands at all three sizes, exercise carry, auxiliary carry and overflow under realistic sign combinations. Logic and shift classes with arbitrary results separate the class-dependent clearing of carry, overflow and auxiliary carry from the arithmetic rules. Directed vectors place a zero or sign-bit result only inside the byte or half width, with nonzero upper bits, which shows whether zero and sign honour the operand size. Random control writes with garbage in the ignored bit positions, interleaved with cycles without write enable, together with pointer-step checks in both directions, confirm the storage mask and the hold behaviour.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'd0,
        OPC_SUB   = 2'd1,
        OPC_LOGIC = 2'd2,
        OPC_SHIFT = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } op_size_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } status_t;

    typedef struct packed {
        logic [5:0] ext;
        logic       nt;
        logic [1:0] iopl;
        logic       dir;
        logic       ien;
        logic       trap;
    } ctrl_t;

    localparam int POS_CF   = 0;
    localparam int POS_ONE  = 1;
    localparam int POS_PF   = 2;
    localparam int POS_AF   = 4;
    localparam int POS_ZF   = 6;
    localparam int POS_SF   = 7;
    localparam int POS_TRAP = 8;
    localparam int POS_IEN  = 9;
    localparam int POS_DIR  = 10;
    localparam int POS_OF   = 11;
    localparam int POS_IOPL = 12;
    localparam int POS_NT   = 14;
    localparam int POS_EXT  = 16;
    localparam int EXT_W    = 6;

    localparam logic [31:0] CTRL_MASK = 32'h003F_7700;

endpackage

// File: rtl/flag_eval.sv
module flag_eval
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_class_e         op,
    input  op_size_e          size,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] r,
    input  logic              cy,
    output status_t           st
);
    localparam int HALF_W = DATA_W / 2;
    localparam int BYTE_W = 8;

    logic sa, sb, sr;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] nib_x;

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                sa = a[BYTE_W-1]; sb = b[BYTE_W-1]; sr = r[BYTE_W-1];
                mask = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
            end
            SZ_HALF: begin
                sa = a[HALF_W-1]; sb = b[HALF_W-1]; sr = r[HALF_W-1];
                mask = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
            end
            default: begin
                sa = a[DATA_W-1]; sb = b[DATA_W-1]; sr = r[DATA_W-1];
                mask = {DATA_W{1'b1}};
            end
        endcase

        nib_x = a ^ b ^ r;

        st.pf = ~^r[BYTE_W-1:0];
        st.zf = ((r & mask) == '0);
        st.sf = sr;

        unique case (op)
            OPC_ADD: begin
                st.cf = cy;
                st.af = nib_x[4];
                st.of = (sa == sb) && (sr != sa);
            end
            OPC_SUB: begin
                st.cf = cy;
                st.af = nib_x[4];
                st.of = (sa != sb) && (sr != sa);
            end
            OPC_SHIFT: begin
                st.cf = cy;
                st.af = 1'b0;
                st.of = (sr != sa);
            end
            default: begin
                st.cf = 1'b0;
                st.af = 1'b0;
                st.of = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ctrl_flag_reg.sv
module ctrl_flag_reg
    import alu_flags_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output ctrl_t       ctrl
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (we) begin
            ctrl_d.trap = wdata[POS_TRAP];
            ctrl_d.ien  = wdata[POS_IEN];
            ctrl_d.dir  = wdata[POS_DIR];
            ctrl_d.iopl = wdata[POS_IOPL +: 2];
            ctrl_d.nt   = wdata[POS_NT];
            ctrl_d.ext  = wdata[POS_EXT +: EXT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;

    p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> (ctrl_q == $past(ctrl_q)));

    p_ctrl_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (ctrl_q.dir == $past(wdata[POS_DIR])));

endmodule

// File: rtl/ptr_step_gen.sv
module ptr_step_gen
    import alu_flags_pkg::*;
#(
    parameter int STEP_W = 4
) (
    input  logic                     dir,
    input  op_size_e                 size,
    output logic signed [STEP_W-1:0] step
);
    logic signed [STEP_W-1:0] mag;

    always_comb begin
        unique case (size)
            SZ_BYTE: mag = STEP_W'(1);
            SZ_HALF: mag = STEP_W'(2);
            default: mag = STEP_W'(4);
        endcase
        step = dir ? -mag : mag;
    end

endmodule

// File: rtl/alu_status_flags.sv
module alu_status_flags
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STEP_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               op_class,
    input  logic [1:0]               op_size,
    input  logic [DATA_W-1:0]        opnd_a,
    input  logic [DATA_W-1:0]        opnd_b,
    input  logic [DATA_W-1:0]        result,
    input  logic                     carry_in,
    input  logic                     ctl_we,
    input  logic [31:0]              ctl_wdata,
    output logic [31:0]              flags_word,
    output logic signed [STEP_W-1:0] ptr_step
);
    op_class_e op_e;
    op_size_e  sz_e;
    status_t   status_d, status_q;
    ctrl_t     ctrl;

    assign op_e = op_class_e'(op_class);
    assign sz_e = op_size_e'(op_size);

    flag_eval #(.DATA_W(DATA_W)) u_eval (
        .op   (op_e),
        .size (sz_e),
        .a    (opnd_a),
        .b    (opnd_b),
        .r    (result),
        .cy   (carry_in),
        .st   (status_d)
    );

    ctrl_flag_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .ctrl  (ctrl)
    );

    ptr_step_gen #(.STEP_W(STEP_W)) u_step (
        .dir  (ctrl.dir),
        .size (sz_e),
        .step (ptr_step)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    always_comb begin
        flags_word                     = '0;
        flags_word[POS_ONE]            = 1'b1;
        flags_word[POS_CF]             = status_q.cf;
        flags_word[POS_PF]             = status_q.pf;
        flags_word[POS_AF]             = status_q.af;
        flags_word[POS_ZF]             = status_q.zf;
        flags_word[POS_SF]             = status_q.sf;
        flags_word[POS_OF]             = status_q.of;
        flags_word[POS_TRAP]           = ctrl.trap;
        flags_word[POS_IEN]            = ctrl.ien;
        flags_word[POS_DIR]            = ctrl.dir;
        flags_word[POS_IOPL +: 2]      = ctrl.iopl;
        flags_word[POS_NT]             = ctrl.nt;
        flags_word[POS_EXT +: EXT_W]   = ctrl.ext;
    end

    p_fixed_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        flags_word[1] && !flags_word[3] && !flags_word[5] && !flags_word[15]
        && (flags_word[31:22] == '0));

    p_logic_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'd2) |=> (!flags_word[0] && !flags_word[4] && !flags_word[11]));

    p_carry_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class != 2'd2) |=> (flags_word[0] == $past(carry_in)));

    p_byte_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_size == 2'd0) |=> (flags_word[6] == ($past(result[7:0]) == 8'h00)));

    p_step_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flags_word[10] == (ptr_step < 0));

endmodule

// File: tb/alu_status_flags_tb.sv
module alu_status_flags_tb;
    localparam int DATA_W = 32;
    localparam int STEP_W = 4;
    localparam logic [31:0] WR_MASK = 32'h003F_7700;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] op_class = '0;
    logic [1:0] op_size = '0;
    logic [DATA_W-1:0] opnd_a = '0, opnd_b = '0, result = '0;
    logic carry_in = 1'b0;
    logic ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] flags_word;
    logic signed [STEP_W-1:0] ptr_step;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] ctl_model = '0;

    always #4 clk = ~clk;

    alu_status_flags #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_class(op_class), .op_size(op_size),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .carry_in(carry_in),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .flags_word(flags_word),
        .ptr_step(ptr_step)
    );

    function automatic logic [31:0] exp_status(input logic [1:0] op, input logic [1:0] sz,
        input logic [31:0] a, input logic [31:0] b, input logic [31:0] r, input logic cy);
        int w;
        logic [31:0] m, e;
        logic sa, sb, sr;
        int ones;
        w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        sa = a[w-1]; sb = b[w-1]; sr = r[w-1];
        ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(r[i]);
        e = 32'h2;
        e[2] = (ones % 2) == 0;
        e[6] = (r & m) == 32'd0;
        e[7] = sr;
        case (op)
            2'd0: begin e[0] = cy; e[4] = a[4] ^ b[4] ^ r[4]; e[11] = (sa == sb) && (sr != sa); end
            2'd1: begin e[0] = cy; e[4] = a[4] ^ b[4] ^ r[4]; e[11] = (sa != sb) && (sr != sa); end
            2'd3: begin e[0] = cy; e[11] = (sr != sa); end
            default: ;
        endcase
        return e;
    endfunction

    function automatic int exp_step(input logic [1:0] sz, input logic d);
        int mag;
        mag = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        return d ? -mag : mag;
    endfunction

    task automatic chk_word(input string req, input logic [31:0] exp);
        n_chk++;
        if (flags_word !== exp) begin
            n_bad++;
            $display("FAIL %s flags_word actual=%08h expected=%08h", req, flags_word, exp);
        end
    endtask

    // drive at negedge, check step, clock, check word at next negedge
    task automatic apply(input string req, input logic [1:0] op, input logic [1:0] sz,
        input logic [31:0] a, input logic [31:0] b, input logic [31:0] r, input logic cy,
        input logic we, input logic [31:0] wd);
        op_class = op; op_size = sz; opnd_a = a; opnd_b = b; result = r;
        carry_in = cy; ctl_we = we; ctl_wdata = wd;
        #1;
        n_chk++;
        if (int'(ptr_step) != exp_step(sz, ctl_model[10])) begin
            n_bad++;
            $display("FAIL R9 ptr_step actual=%0d expected=%0d", ptr_step, exp_step(sz, ctl_model[10]));
        end
        @(posedge clk);
        if (we) ctl_model = wd & WR_MASK;
        @(negedge clk);
        chk_word(req, exp_status(op, sz, a, b, r, cy) | ctl_model);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk_word("R10 reset", 32'h0000_0002);
        chk_word("R1 reset layout", 32'h0000_0002);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corner cases
        apply("R5 byte zero, upper bits set", 2'd2, 2'd0, 32'h0, 32'h0, 32'hFFFF_FF00, 1'b0, 1'b0, 32'h0);
        apply("R5 half nonzero", 2'd2, 2'd1, 32'h0, 32'h0, 32'h0001_0001, 1'b0, 1'b0, 32'h0);
        apply("R6 byte sign", 2'd2, 2'd0, 32'h0, 32'h0, 32'h0000_0080, 1'b0, 1'b0, 32'h0);
        apply("R7 byte add overflow", 2'd0, 2'd0, 32'h7F, 32'h01, 32'h80, 1'b0, 1'b0, 32'h0);
        apply("R7 word sub overflow", 2'd1, 2'd2, 32'h8000_0000, 32'h1, 32'h7FFF_FFFF, 1'b0, 1'b0, 32'h0);
        apply("R4 nibble carry", 2'd0, 2'd0, 32'h0F, 32'h01, 32'h10, 1'b0, 1'b0, 32'h0);
        apply("R2 logic clears carry", 2'd2, 2'd2, 32'hFFFF_FFFF, 32'h1, 32'h0000_0007, 1'b1, 1'b0, 32'h0);
        apply("R2 shift carry", 2'd3, 2'd1, 32'h8001, 32'h1, 32'h0002, 1'b1, 1'b0, 32'h0);
        apply("R3 parity odd", 2'd2, 2'd2, 32'h0, 32'h0, 32'h0000_0107, 1'b0, 1'b0, 32'h0);
        apply("R8 write with ignored bits", 2'd2, 2'd0, 32'h0, 32'h0, 32'h1, 1'b0, 1'b1, 32'hFFFF_FFFF);
        apply("R8 hold without enable", 2'd2, 2'd0, 32'h0, 32'h0, 32'h1, 1'b0, 1'b0, 32'h0);
        apply("R9 step negative", 2'd2, 2'd1, 32'h0, 32'h0, 32'h1, 1'b0, 1'b1, 32'h0000_0000);
        apply("R9 step positive", 2'd2, 2'd3, 32'h0, 32'h0, 32'h1, 1'b0, 1'b0, 32'h0);

        for (int k = 0; k < 2000; k++) begin
            logic [1:0] op, sz;
            logic [31:0] a, b, r, m;
            logic cy;
            logic [32:0] wide;
            op = 2'($urandom_range(0, 3));
            sz = 2'($urandom_range(0, 3));
            a = $urandom; b = $urandom;
            m = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
            if (op == 2'd0) begin
                wide = {1'b0, a & m} + {1'b0, b & m};
                r = wide[31:0] & m;
                cy = (wide[31:0] > m) || wide[32];
            end else if (op == 2'd1) begin
                r = ((a & m) - (b & m)) & m;
                cy = (a & m) < (b & m);
            end else begin
                r = $urandom; cy = 1'($urandom);
            end
            apply((op == 2'd3) ? "R7 random shift" : (op == 2'd2) ? "R2 random logic" : "R4 random arith",
                  op, sz, a, b, r, cy, ($urandom_range(0, 7) == 0), $urandom);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule